// File: doc/BRIEF.md
# Bidirectional Johnson-Ring Terminal-Count Generator

This block is the prescaler stage placed inside each section of a long up/down counter. It keeps a twisted-ring (Johnson) state of `STAGES` flip-flops, so it walks through a cycle of `2*STAGES` distinct states. On every enabled clock it advances one state forward or one state backward, depending on the direction input. Once per full lap it raises a terminal-count strobe, which the next, wider section takes as its carry-in (counting up) or borrow-in (counting down).

The terminal states are decoded from two state bits only, so the strobe settles in a constant number of gate delays for any ring length. Counting up, the strobe marks the state in which only the top bit is set. Counting down, it marks the all-zero state. Because the ring steps backward through exactly the states it stepped forward through, a change of direction retraces the recent history without any extra storage. If a disturbance leaves the ring in a pattern no Johnson sequence can reach, the next enabled clock clears it to all zeros.

Top module: `twring_tc_gen`

## Requirements
- R1: While `rst_n` is low, `ring` reads all zeros. Reset is asynchronous.
- R2: With `en`=1 and `dn`=0, a legal state shifts one place toward bit 0 on the clock. The inverse of bit 0 enters at bit `STAGES-1`. With 4 stages the visible order is 0000, 1000, 1100, 1110, 1111, 0111, 0011, 0001, and then it repeats.
- R3: With `en`=1 and `dn`=1, a legal state shifts one place toward the top bit on the clock. The inverse of bit `STAGES-1` enters at bit 0. This walks the R2 order backward.
- R4: With `en`=0, `ring` keeps its value across the clock and `tc` is 0, whatever `dn` is.
- R5: With `dn`=0, `tc` is 1 exactly when `en`=1, `ring[STAGES-1]`=1 and `ring[STAGES-2]`=0. In a legal state this is the pattern with only the top bit set.
- R6: With `dn`=1, `tc` is 1 exactly when `en`=1, `ring[STAGES-1]`=0 and `ring[0]`=0. In a legal state this is the all-zero pattern.
- R7: Over any `2*STAGES` consecutive enabled cycles in one direction, `tc` is high in exactly one of them.
- R8: If one enabled step in one direction is followed directly by one enabled step in the other direction, `ring` returns to the value it held before the first step.
- R9: A pattern with more than one 0/1 boundary between adjacent bits is illegal. On the next enabled clock an illegal pattern becomes all zeros in either direction.
- R10: After `2*STAGES` enabled steps in one direction, `ring` returns to its starting value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to `clk` |
| en | input | 1 | Step enable (carry/borrow-in from the lower section) |
| dn | input | 1 | Direction: 0 counts up, 1 counts down |
| ring | output | STAGES | Present Johnson ring state |
| tc | output | 1 | Terminal-count strobe for the next section |

## Verification
The properties assume that `rst_n` is released away from a clock edge and that `en` and `dn` stay stable across each rising edge. The retrace and terminal-pattern properties also assume that the ring holds a legal Johnson pattern, which is always true when the ring is reached only through its ports. The bench builds an illegal state only by overriding the next-state net for one clock. It puts an idle cycle between such an injection and any change of direction, so the retrace property never sees a planted pattern.

// File: rtl/twring_pkg.sv
package twring_pkg;
  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } twring_dir_e;
endpackage

// File: rtl/twring_step.sv
// Next-state logic: shift in the selected direction, or clear an illegal pattern.
module twring_step
  import twring_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] cur,
  input  twring_dir_e  dir,
  output wire  [W-1:0] nxt,
  output logic         legal
);
  localparam int EW = W - 1;

  logic [EW-1:0] edges;
  logic [W-1:0]  shift_up;
  logic [W-1:0]  shift_dn;
  logic [W-1:0]  nxt_c;

  // One boundary flag for each adjacent pair of bits.
  for (genvar g = 0; g < EW; g++) begin : g_edge
    assign edges[g] = cur[g+1] ^ cur[g];
  end

  // Legal Johnson patterns have at most one boundary.
  assign legal = ((edges & (edges - EW'(1))) == '0);

  always_comb begin
    shift_up = {~cur[0], cur[W-1:1]};
    shift_dn = {cur[W-2:0], ~cur[W-1]};
    if (!legal)                nxt_c = '0;
    else if (dir == DIR_DOWN)  nxt_c = shift_dn;
    else                       nxt_c = shift_up;
  end

  assign nxt = nxt_c;
endmodule

// File: rtl/twring_term.sv
// Two-bit terminal decode, gated by the step enable.
module twring_term
  import twring_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] cur,
  input  twring_dir_e  dir,
  input  logic         en,
  output logic         tc
);
  logic hit_up;
  logic hit_dn;

  always_comb begin
    hit_up = cur[W-1] & ~cur[W-2];
    hit_dn = ~cur[W-1] & ~cur[0];
    tc     = en & ((dir == DIR_DOWN) ? hit_dn : hit_up);
  end
endmodule

// File: rtl/twring_reg.sv
// State register with a clock enable and an asynchronous clear.
module twring_reg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= d;
  end
endmodule

// File: rtl/twring_tc_gen.sv
// Bidirectional Johnson-ring prescaler with a constant-time terminal count.
// STAGES must be at least 2; the ring cycles through 2*STAGES states.
module twring_tc_gen
  import twring_pkg::*;
#(
  parameter int STAGES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              dn,
  output logic [STAGES-1:0] ring,
  output logic              tc
);
  twring_dir_e        dir;
  wire [STAGES-1:0]   ring_nxt;
  logic               ring_legal;
  logic [STAGES-1:0]  ring_q;

  assign dir = twring_dir_e'(dn);

  twring_step #(.W(STAGES)) u_step (
    .cur   (ring_q),
    .dir   (dir),
    .nxt   (ring_nxt),
    .legal (ring_legal)
  );

  twring_reg #(.W(STAGES)) u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en),
    .d     (ring_nxt),
    .q     (ring_q)
  );

  twring_term #(.W(STAGES)) u_term (
    .cur (ring_q),
    .dir (dir),
    .en  (en),
    .tc  (tc)
  );

  assign ring = ring_q;
endmodule

// File: rtl/twring_tc_gen_chk.sv
module twring_tc_gen_chk #(
  parameter int STAGES = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic              dn,
  input logic [STAGES-1:0] ring,
  input logic              tc
);
  localparam logic [STAGES-1:0] TOP_ONLY = {1'b1, {(STAGES-1){1'b0}}};

  function automatic logic is_johnson(input logic [STAGES-1:0] s);
    return $countones(s[STAGES-1:1] ^ s[STAGES-2:0]) <= 1;
  endfunction

  // R4
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(ring));

  // R4
  no_tc_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !tc);

  // R5
  up_tc_pattern_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tc && !dn && is_johnson(ring)) |-> (ring == TOP_ONLY));

  // R5
  up_tc_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !dn && ring == TOP_ONLY) |-> tc);

  // R6
  down_tc_pattern_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tc && dn && is_johnson(ring)) |-> (ring == '0));

  // R6
  down_tc_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && dn && ring == '0) |-> tc);

  // R8
  retrace_up_dn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !dn) ##1 (en && dn) |=> (ring == $past(ring, 2)));

  // R8
  retrace_dn_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && dn) ##1 (en && !dn) |=> (ring == $past(ring, 2)));

  // R9
  illegal_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !is_johnson(ring)) |=> (ring == '0));
endmodule

bind twring_tc_gen twring_tc_gen_chk #(.STAGES(STAGES)) chk_i (
  .clk   (clk),
  .rst_n (rst_n),
  .en    (en),
  .dn    (dn),
  .ring  (ring),
  .tc    (tc)
);

// File: tb/twring_tc_gen_tb_top.sv
`timescale 1ns/1ps
module twring_tc_gen_tb_top;
  localparam int W     = 4;
  localparam int M     = 2 * W;
  localparam int NV    = 18;
  localparam int LIMIT = 200000;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         en;
  logic         dn;
  logic [W-1:0] ring;
  logic         tc;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  twring_tc_gen #(.STAGES(W)) dut_i (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en),
    .dn    (dn),
    .ring  (ring),
    .tc    (tc)
  );

  // Each entry: {en, dn, ring after the clock, tc before the clock}
  localparam logic [6:0] VEC [NV] = '{
    {1'b1, 1'b0, 4'b1000, 1'b0},
    {1'b1, 1'b0, 4'b1100, 1'b1},
    {1'b1, 1'b0, 4'b1110, 1'b0},
    {1'b1, 1'b0, 4'b1111, 1'b0},
    {1'b1, 1'b0, 4'b0111, 1'b0},
    {1'b1, 1'b0, 4'b0011, 1'b0},
    {1'b1, 1'b0, 4'b0001, 1'b0},
    {1'b1, 1'b0, 4'b0000, 1'b0},
    {1'b0, 1'b0, 4'b0000, 1'b0},
    {1'b0, 1'b1, 4'b0000, 1'b0},
    {1'b1, 1'b1, 4'b0001, 1'b1},
    {1'b1, 1'b1, 4'b0011, 1'b0},
    {1'b1, 1'b0, 4'b0001, 1'b0},
    {1'b1, 1'b0, 4'b0000, 1'b0},
    {1'b1, 1'b0, 4'b1000, 1'b0},
    {1'b0, 1'b0, 4'b1000, 1'b0},
    {1'b1, 1'b1, 4'b0000, 1'b0},
    {1'b1, 1'b1, 4'b0001, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Step count enabled cycles from the current state and count tc strobes.
  task automatic lap(input logic d, input int n, output int hits);
    hits = 0;
    for (int k = 0; k < n; k++) begin
      en = 1'b1; dn = d;
      #2;
      if (tc === 1'b1) hits++;
      @(posedge clk);
      @(negedge clk);
    end
    en = 1'b0;
  endtask

  initial begin
    #(20.0 * LIMIT);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int hits;
    logic [W-1:0] start;
    rst_n = 1'b0; en = 1'b1; dn = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset state", ring, 4'b0000);
    en = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);

    // Table walk: R2 R3 R4 R5 R6 R8
    for (int i = 0; i < NV; i++) begin
      en = VEC[i][6];
      dn = VEC[i][5];
      #2;
      chk($sformatf("R5/R6/R4 tc vector %0d", i), tc, VEC[i][0]);
      @(posedge clk);
      @(negedge clk);
      chk($sformatf("R2/R3/R4/R8 ring vector %0d", i), ring, VEC[i][4:1]);
    end
    en = 1'b0;

    // R7 R10: three laps up from the present state
    start = ring;
    lap(1'b0, 3 * M, hits);
    chk("R7 up strobes in three laps", hits, 3);
    chk("R10 up lap returns to start", ring, start);

    // R7 R10: three laps down
    lap(1'b1, 3 * M, hits);
    chk("R7 down strobes in three laps", hits, 3);
    chk("R10 down lap returns to start", ring, start);

    // R4: idle over several clocks with dn toggling
    start = ring;
    for (int k = 0; k < 4; k++) begin
      en = 1'b0; dn = k[0];
      #2;
      chk("R4 idle tc", tc, 1'b0);
      @(posedge clk);
      @(negedge clk);
      chk("R4 idle hold", ring, start);
    end

    // R9: plant 0101 through the next-state net, then step up
    en = 1'b1; dn = 1'b0;
    force dut_i.ring_nxt = 4'b0101;
    @(posedge clk);
    @(negedge clk);
    release dut_i.ring_nxt;
    en = 1'b0;
    @(posedge clk);
    @(negedge clk);
    en = 1'b1; dn = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R9 illegal 0101 cleared counting up", ring, 4'b0000);
    en = 1'b0;
    @(posedge clk);
    @(negedge clk);

    // R9: plant 1011 then step down
    en = 1'b1; dn = 1'b1;
    force dut_i.ring_nxt = 4'b1011;
    @(posedge clk);
    @(negedge clk);
    release dut_i.ring_nxt;
    en = 1'b0;
    @(posedge clk);
    @(negedge clk);
    en = 1'b1; dn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R9 illegal 1011 cleared counting down", ring, 4'b0000);
    en = 1'b0;
    @(posedge clk);
    @(negedge clk);

    // R1: asynchronous reset in mid-sequence
    lap(1'b0, 3, hits);
    chk("R2 three steps up from zero", ring, 4'b1110);
    rst_n = 1'b0;
    #2;
    chk("R1 async reset mid-run", ring, 4'b0000);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    lap(1'b1, 1, hits);
    chk("R6 strobe at zero after reset", hits, 1);
    chk("R3 first down step after reset", ring, 4'b0001);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule